// File: doc/BRIEF.md
# Interrupt Arbiter and Vector Sequencer

This block sits beside the control unit of a small 16-bit processor core that runs in either a compatibility (emulation) mode or a native mode. It takes the four raw active-low request pins (reset, abort, non-maskable, maskable), passes them through a synchronizer and keeps the edge-type and pulse-type requests in latches. It picks one winner when the core signals an instruction boundary. It then runs a fixed-length entry sequence. In the last two cycles of that sequence it puts the bank-zero vector address on its address output and holds the active-low vector-pull strobe low. In the first cycle it pulses the side-effect strobes that tell the core to set the interrupt-disable flag, clear the decimal flag and handle the bank registers.

The block also owns the wait state. When the core reports a wait-for-interrupt instruction, the ready output drops. Any request releases it. When the maskable request arrives with the disable flag set, the core only gets a one-cycle resume pulse and no vector is fetched. An abort raises a cancel output at once, so the core can suppress the register writes of the current instruction. During the abort sequence a restart output tells the core to push the address of the aborted opcode.

Top module: `irq_vec_seq`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are idle: busy low, source 0, vector-pull high, address 0, every side-effect strobe low, cancel low, ready high and resume low.
- R2: In native mode (mode flag 0 when the sequence starts) the vector low/high bytes are read from 00FFE8/00FFE9 for abort, 00FFEA/00FFEB for the non-maskable request and 00FFEE/00FFEF for the maskable request.
- R3: In emulation mode (mode flag 1) the vector bytes come from 00FFF8/9 for abort, 00FFFA/B for non-maskable and 00FFFE/F for maskable. A reset sequence uses 00FFFC/D in both modes.
- R4: A sequence lasts SEQ_LEN cycles with busy high. Vector-pull is low for exactly the last two of them. The address shows the low-byte location first and the high-byte location second, and it is 0 whenever vector-pull is high. The source code is 0 reset, 1 abort, 2 non-maskable, 3 maskable.
- R5: When several requests are pending at one start, reset wins over abort, abort wins over non-maskable, and non-maskable wins over maskable. The losers stay pending and are taken at later boundaries.
- R6: The maskable request is a level. It is taken only at a boundary (or in the wait state) while the disable flag is 0. A request that is withdrawn before that point is never taken.
- R7: The non-maskable request is taken once per high-to-low transition. Holding it low does not trigger it again. A fall that occurs during a sequence is kept and taken afterwards.
- R8: In the first sequence cycle, the set-disable, clear-decimal and program-bank-clear strobes pulse for every source. In native mode a non-reset source also pulses the save-program-bank strobe. In emulation mode, and for reset, the data-bank-clear strobe pulses and save-program-bank does not.
- R9: Cancel goes high once an abort request is latched. It stays high until the second cycle of the abort sequence, and it is low again from the third cycle on. Restart is high throughout an abort sequence.
- R10: A wait-instruction strobe outside a sequence drops ready. A latched reset, abort, non-maskable or enabled maskable request starts its sequence at once and raises ready. A maskable request with the disable flag set raises ready and pulses resume for one cycle, and no sequence starts.
- R11: While the synchronized reset pin is low, any sequence and wait state end and pending abort and non-maskable requests are dropped. After the pin returns high, the reset sequence starts without a boundary.
- R12: Each request pin passes through SYNC_STAGES flops. With the default of 2, a maskable request driven before clock edge n, with the boundary held high, starts a sequence at edge n+2, so busy is seen high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_n_i | input | 1 | Raw reset request, active low |
| abort_n_i | input | 1 | Raw abort request, active low, pulse sensitive |
| nmi_n_i | input | 1 | Raw non-maskable request, falling-edge sensitive |
| irq_n_i | input | 1 | Raw maskable request, active-low level |
| i_flag_i | input | 1 | Interrupt-disable flag from the core |
| e_flag_i | input | 1 | Mode flag from the core, 1 = emulation |
| boundary_i | input | 1 | Instruction-boundary strobe |
| wai_i | input | 1 | Wait-for-interrupt instruction strobe |
| vec_addr_o | output | 24 | Vector byte address during the pull cycles |
| vec_pull_n_o | output | 1 | Vector-pull strobe, active low |
| seq_busy_o | output | 1 | Entry sequence in progress |
| seq_src_o | output | 2 | Source of the running sequence |
| set_i_o | output | 1 | Set the interrupt-disable flag |
| clr_d_o | output | 1 | Clear the decimal flag |
| pbr_clr_o | output | 1 | Clear the program bank register |
| dbr_clr_o | output | 1 | Clear the data bank register |
| save_pbr_o | output | 1 | Push the old program bank before clearing it |
| restart_op_o | output | 1 | Return address is the aborted opcode |
| cancel_o | output | 1 | Suppress register writes of the current instruction |
| ready_o | output | 1 | Low while the wait state holds the core |
| resume_o | output | 1 | Masked request ended the wait without a vector |

## Verification
The hardest state to reach is a pile-up of requests. In it an abort pulse, a non-maskable fall and a held maskable level are all latched before one boundary, and every loser must survive the sequence of the winner. The bench arms all three with no boundary active. It waits for the synchronizer, then issues boundaries spaced wider than a sequence and checks the order of sources and vectors. The wait state with a masked request is reached by raising the disable flag before the wait strobe. A long random phase then mixes the flags, the pins, reset pulses and boundaries against a per-cycle reference model.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [1:0] {
    SRC_RST = 2'd0,
    SRC_ABT = 2'd1,
    SRC_NMI = 2'd2,
    SRC_IRQ = 2'd3
  } irq_src_e;

  localparam logic [7:0] VEC_BANK = 8'h00;

  // low-byte location of each vector in bank zero
  function automatic logic [15:0] vec_base(irq_src_e src, logic emu);
    case (src)
      SRC_RST: return 16'hFFFC;
      SRC_ABT: return emu ? 16'hFFF8 : 16'hFFE8;
      SRC_NMI: return emu ? 16'hFFFA : 16'hFFEA;
      default: return emu ? 16'hFFFE : 16'hFFEE;
    endcase
  endfunction

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  // requests are active low, so the idle value is all ones
  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '1;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     res_s,
  input  logic     abt_s,
  input  logic     nmi_s,
  input  logic     irq_s,
  input  logic     i_flag_i,
  input  logic     take_i,
  input  irq_src_e take_src_i,
  input  logic     abt_clr_i,
  output logic     abt_pend_o,
  output logic     win_valid_o,
  output irq_src_e win_src_o
);

  logic res_pend, nmi_pend, nmi_prev, nmi_fall;

  assign nmi_fall = nmi_prev & ~nmi_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_pend   <= 1'b0;
      abt_pend_o <= 1'b0;
      nmi_pend   <= 1'b0;
      nmi_prev   <= 1'b1;
    end else begin
      nmi_prev <= nmi_s;
      if (!res_s) begin
        res_pend   <= 1'b1;
        abt_pend_o <= 1'b0;
        nmi_pend   <= 1'b0;
      end else begin
        if (take_i && take_src_i == SRC_RST) res_pend <= 1'b0;
        if (abt_clr_i)   abt_pend_o <= 1'b0;
        else if (!abt_s) abt_pend_o <= 1'b1;
        if (nmi_fall)    nmi_pend <= 1'b1;
        else if (take_i && take_src_i == SRC_NMI) nmi_pend <= 1'b0;
      end
    end
  end

  // fixed priority: reset, abort, nmi, irq
  always_comb begin
    win_valid_o = 1'b1;
    win_src_o   = SRC_IRQ;
    if (res_pend && res_s)      win_src_o = SRC_RST;
    else if (abt_pend_o)        win_src_o = SRC_ABT;
    else if (nmi_pend)          win_src_o = SRC_NMI;
    else if (!irq_s && !i_flag_i) win_src_o = SRC_IRQ;
    else                        win_valid_o = 1'b0;
  end

  p_nmi_once_r7: assert property (@(posedge clk) disable iff (rst)
    (res_s && take_i && take_src_i == SRC_NMI && !nmi_fall) |=> !nmi_pend);

  p_abort_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (res_s && !abt_s && !abt_clr_i) |=> abt_pend_o);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_vec_pkg::*;
#(
  parameter int SEQ_LEN = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        res_s,
  input  logic        irq_s,
  input  logic        i_flag_i,
  input  logic        e_flag_i,
  input  logic        boundary_i,
  input  logic        wai_i,
  input  logic        win_valid_i,
  input  irq_src_e    win_src_i,
  output logic        take_o,
  output logic        abt_clr_o,
  output logic [23:0] vec_addr_o,
  output logic        vec_pull_n_o,
  output logic        seq_busy_o,
  output logic [1:0]  seq_src_o,
  output logic        set_i_o,
  output logic        clr_d_o,
  output logic        pbr_clr_o,
  output logic        dbr_clr_o,
  output logic        save_pbr_o,
  output logic        restart_op_o,
  output logic        ready_o,
  output logic        resume_o
);

  localparam int CW = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 2;
  localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);
  localparam logic [CW-1:0] PULL = CW'(SEQ_LEN - 2);

  logic          busy, emu_q, waiting, wake;
  logic [CW-1:0] cnt;
  irq_src_e      src_q;
  logic          in_pull, first;
  logic [15:0]   addr_lo;

  assign take_o = res_s && !busy && win_valid_i &&
                  (win_src_i == SRC_RST || boundary_i || waiting);
  assign wake   = waiting && res_s && !irq_s && i_flag_i && !win_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      src_q    <= SRC_RST;
      emu_q    <= 1'b0;
      waiting  <= 1'b0;
      resume_o <= 1'b0;
    end else begin
      resume_o <= wake;
      if (!res_s) begin
        busy    <= 1'b0;
        cnt     <= '0;
        waiting <= 1'b0;
      end else begin
        if (take_o) begin
          busy  <= 1'b1;
          cnt   <= '0;
          src_q <= win_src_i;
          emu_q <= e_flag_i;
        end else if (busy) begin
          if (cnt == LAST) begin
            busy <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (take_o || wake)       waiting <= 1'b0;
        else if (wai_i && !busy)  waiting <= 1'b1;
      end
    end
  end

  assign in_pull   = busy && (cnt >= PULL);
  assign first     = busy && (cnt == '0);
  assign addr_lo   = vec_base(src_q, emu_q) + {15'd0, cnt == LAST};
  assign abt_clr_o = busy && (cnt == CW'(1)) && (src_q == SRC_ABT);

  assign vec_addr_o   = in_pull ? {VEC_BANK, addr_lo} : 24'h0;
  assign vec_pull_n_o = ~in_pull;
  assign seq_busy_o   = busy;
  assign seq_src_o    = busy ? src_q : 2'd0;
  assign set_i_o      = first;
  assign clr_d_o      = first;
  assign pbr_clr_o    = first;
  assign dbr_clr_o    = first && (emu_q || src_q == SRC_RST);
  assign save_pbr_o   = first && !emu_q && src_q != SRC_RST;
  assign restart_op_o = busy && src_q == SRC_ABT;
  assign ready_o      = ~waiting;

  p_pull_pair_r4: assert property (@(posedge clk) disable iff (rst || !res_s)
    $fell(vec_pull_n_o) |=> !vec_pull_n_o);

  p_pull_end_r4: assert property (@(posedge clk) disable iff (rst || !res_s)
    (!vec_pull_n_o && $past(!vec_pull_n_o)) |=> vec_pull_n_o);

  p_vec_bank_r2: assert property (@(posedge clk) disable iff (rst)
    !vec_pull_n_o |-> vec_addr_o[23:8] == 16'h00FF);

  p_fx_once_r8: assert property (@(posedge clk) disable iff (rst)
    set_i_o |=> !set_i_o);

endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
  import irq_vec_pkg::*;
#(
  parameter int SEQ_LEN     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        res_n_i,
  input  logic        abort_n_i,
  input  logic        nmi_n_i,
  input  logic        irq_n_i,
  input  logic        i_flag_i,
  input  logic        e_flag_i,
  input  logic        boundary_i,
  input  logic        wai_i,
  output logic [23:0] vec_addr_o,
  output logic        vec_pull_n_o,
  output logic        seq_busy_o,
  output logic [1:0]  seq_src_o,
  output logic        set_i_o,
  output logic        clr_d_o,
  output logic        pbr_clr_o,
  output logic        dbr_clr_o,
  output logic        save_pbr_o,
  output logic        restart_op_o,
  output logic        cancel_o,
  output logic        ready_o,
  output logic        resume_o
);

  logic [3:0] raw, syn;
  logic       take, abt_clr, win_valid;
  irq_src_e   win_src;

  assign raw = {irq_n_i, nmi_n_i, abort_n_i, res_n_i};

  irq_req_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(syn)
  );

  irq_arbiter u_arb (
    .clk(clk), .rst(rst),
    .res_s(syn[0]), .abt_s(syn[1]), .nmi_s(syn[2]), .irq_s(syn[3]),
    .i_flag_i(i_flag_i), .take_i(take), .take_src_i(win_src),
    .abt_clr_i(abt_clr), .abt_pend_o(cancel_o),
    .win_valid_o(win_valid), .win_src_o(win_src)
  );

  irq_seq_fsm #(.SEQ_LEN(SEQ_LEN)) u_seq (
    .clk(clk), .rst(rst), .res_s(syn[0]), .irq_s(syn[3]),
    .i_flag_i(i_flag_i), .e_flag_i(e_flag_i), .boundary_i(boundary_i),
    .wai_i(wai_i), .win_valid_i(win_valid), .win_src_i(win_src),
    .take_o(take), .abt_clr_o(abt_clr),
    .vec_addr_o(vec_addr_o), .vec_pull_n_o(vec_pull_n_o),
    .seq_busy_o(seq_busy_o), .seq_src_o(seq_src_o),
    .set_i_o(set_i_o), .clr_d_o(clr_d_o), .pbr_clr_o(pbr_clr_o),
    .dbr_clr_o(dbr_clr_o), .save_pbr_o(save_pbr_o),
    .restart_op_o(restart_op_o), .ready_o(ready_o), .resume_o(resume_o)
  );

  p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
    (take && win_src == SRC_IRQ) |-> !i_flag_i);

  p_resume_ready_r10: assert property (@(posedge clk) disable iff (rst)
    resume_o |-> (ready_o && !seq_busy_o));

  p_cancel_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (restart_op_o && !vec_pull_n_o) |-> !$past(set_i_o));

endmodule

// File: tb/tb_irq_vec_seq.sv
`timescale 1ns/1ps
module tb_irq_vec_seq;
  localparam int L = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic res_n = 1, abt_n = 1, nmi_n = 1, irq_n = 1;
  logic i_flag = 0, e_flag = 0, boundary = 0, wai = 0;
  logic [23:0] vec_addr;
  logic vec_pull_n, busy, set_i, clr_d, pbr_clr, dbr_clr, save_pbr;
  logic restart, cancel, ready, resume;
  logic [1:0] src;

  always #2.5 clk = ~clk;

  irq_vec_seq #(.SEQ_LEN(L), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .res_n_i(res_n), .abort_n_i(abt_n),
    .nmi_n_i(nmi_n), .irq_n_i(irq_n), .i_flag_i(i_flag), .e_flag_i(e_flag),
    .boundary_i(boundary), .wai_i(wai), .vec_addr_o(vec_addr),
    .vec_pull_n_o(vec_pull_n), .seq_busy_o(busy), .seq_src_o(src),
    .set_i_o(set_i), .clr_d_o(clr_d), .pbr_clr_o(pbr_clr),
    .dbr_clr_o(dbr_clr), .save_pbr_o(save_pbr), .restart_op_o(restart),
    .cancel_o(cancel), .ready_o(ready), .resume_o(resume)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit p1[4], p2[4];     // pin history: one and two edges ago
  bit m_prevn, m_res, m_abt, m_nmi, m_busy, m_wait, m_resume, m_emu;
  int m_cnt, m_src;

  function automatic int base_of(int s, bit emu);
    case (s)
      0: return 'hFFFC;
      1: return emu ? 'hFFF8 : 'hFFE8;
      2: return emu ? 'hFFFA : 'hFFEA;
      default: return emu ? 'hFFFE : 'hFFEE;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (p1[k]) begin p1[k] = 1; p2[k] = 1; end
      m_prevn = 1; m_res = 0; m_abt = 0; m_nmi = 0; m_busy = 0;
      m_wait = 0; m_resume = 0; m_emu = 0; m_cnt = 0; m_src = 0;
    end else begin
      int w;
      bit st, fall, aclr, wm;
      w = -1;
      if (m_res && p2[0]) w = 0;
      else if (m_abt) w = 1;
      else if (m_nmi) w = 2;
      else if (!p2[3] && !i_flag) w = 3;
      st   = p2[0] && !m_busy && w >= 0 && (w == 0 || boundary || m_wait);
      fall = m_prevn && !p2[2];
      aclr = m_busy && m_cnt == 1 && m_src == 1;
      wm   = m_wait && p2[0] && !p2[3] && i_flag && w < 0;
      m_resume = wm;
      if (!p2[0]) begin
        m_res = 1; m_abt = 0; m_nmi = 0; m_busy = 0; m_cnt = 0; m_wait = 0;
      end else begin
        if (st && w == 0) m_res = 0;
        if (aclr) m_abt = 0; else if (!p2[1]) m_abt = 1;
        if (fall) m_nmi = 1; else if (st && w == 2) m_nmi = 0;
        if (st || wm) m_wait = 0;
        else if (wai && !m_busy) m_wait = 1;
        if (st) begin
          m_busy = 1; m_cnt = 0; m_src = w; m_emu = e_flag;
        end else if (m_busy) begin
          if (m_cnt == L - 1) begin m_busy = 0; m_cnt = 0; end
          else m_cnt++;
        end
      end
      m_prevn = p2[2];
      p2 = p1;
      p1[0] = res_n; p1[1] = abt_n; p1[2] = nmi_n; p1[3] = irq_n;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit pull, fx;
      int ea;
      pull = m_busy && m_cnt >= L - 2;
      fx   = m_busy && m_cnt == 0;
      ea   = pull ? base_of(m_src, m_emu) + (m_cnt == L - 1 ? 1 : 0) : 0;
      chk("R4 busy", busy, m_busy);
      chk("R4 src", src, m_busy ? m_src : 0);
      chk("R4 pull_n", vec_pull_n, !pull);
      chk("R2/R3 addr", vec_addr, ea);
      chk("R8 set_i", set_i, fx);
      chk("R8 clr_d", clr_d, fx);
      chk("R8 pbr_clr", pbr_clr, fx);
      chk("R8 dbr_clr", dbr_clr, fx && (m_emu || m_src == 0));
      chk("R8 save_pbr", save_pbr, fx && !m_emu && m_src != 0);
      chk("R9 cancel", cancel, m_abt);
      chk("R9 restart", restart, m_busy && m_src == 1);
      chk("R10 ready", ready, !m_wait);
      chk("R10 resume", resume, m_resume);
    end
  end

  // port monitor for directed checks
  logic prev_pull = 1, prev_busy = 0;
  logic [15:0] last_vec = 0;
  int seq_count = 0, resume_count = 0;
  int srcs[$];
  always @(negedge clk) begin
    if (rst) begin
      prev_pull = 1; prev_busy = 0;
    end else begin
      if (!vec_pull_n && prev_pull) last_vec = vec_addr[15:0];
      if (busy && !prev_busy) begin seq_count++; srcs.push_back(src); end
      if (resume) resume_count++;
      prev_pull = vec_pull_n; prev_busy = busy;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bnd();
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    cyc(3); rst = 0; cyc(2);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 pull_n", vec_pull_n, 1);
    chk("R1 addr", vec_addr, 0);
    chk("R1 ready", ready, 1);
    chk("R1 strobes", {set_i, clr_d, pbr_clr, dbr_clr, save_pbr, cancel, resume}, 0);

    // R2 R6 native maskable request
    c0 = seq_count;
    irq_n = 0; cyc(4); bnd(); irq_n = 1; cyc(L + 3);
    chk("R2 irq native vector", last_vec, 16'hFFEE);
    chk("R6 one irq sequence", seq_count - c0, 1);

    // R6 masked and withdrawn
    c0 = seq_count;
    i_flag = 1; irq_n = 0; cyc(4); bnd(); cyc(L + 2);
    irq_n = 1; i_flag = 0; cyc(4); bnd(); cyc(3);
    irq_n = 0; cyc(1); irq_n = 1; cyc(5); bnd(); cyc(L + 2);
    chk("R6 masked or withdrawn not taken", seq_count - c0, 0);

    // R3 R7 emulation nmi held low
    c0 = seq_count; e_flag = 1;
    nmi_n = 0; cyc(4); bnd(); cyc(L + 3); bnd(); cyc(L + 3);
    chk("R3 nmi emulation vector", last_vec, 16'hFFFA);
    chk("R7 held nmi taken once", seq_count - c0, 1);
    nmi_n = 1; cyc(2);

    // R12 synchronizer latency
    e_flag = 0;
    @(negedge clk); boundary = 1; irq_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R12 not yet started", busy, 0);
    @(negedge clk);
    chk("R12 started after two stages", busy, 1);
    boundary = 0; irq_n = 1; cyc(L + 3);

    // R5 R9 pile-up of abort, nmi, irq
    srcs.delete();
    abt_n = 0; nmi_n = 0; irq_n = 0; cyc(1); abt_n = 1; cyc(4);
    chk("R9 cancel raised", cancel, 1);
    bnd(); cyc(L + 3);
    chk("R9 cancel cleared", cancel, 0);
    bnd(); cyc(L + 3); bnd(); cyc(L + 3);
    irq_n = 1; nmi_n = 1;
    chk("R5 order count", srcs.size(), 3);
    if (srcs.size() == 3) begin
      chk("R5 first abort", srcs[0], 1);
      chk("R5 then nmi", srcs[1], 2);
      chk("R5 then irq", srcs[2], 3);
    end
    chk("R2 irq after pile-up", last_vec, 16'hFFEE);

    // R7 nmi edge during another sequence
    c0 = seq_count;
    irq_n = 0; cyc(4); bnd(); irq_n = 1; cyc(2);
    nmi_n = 0; cyc(1); nmi_n = 1; cyc(L + 3); bnd(); cyc(L + 3);
    chk("R7 edge during service kept", seq_count - c0, 2);
    chk("R2 nmi native vector", last_vec, 16'hFFEA);

    // R11 R3 reset in both modes, no boundary needed
    res_n = 0; cyc(4); res_n = 1; cyc(L + 6);
    chk("R11 reset vector native", last_vec, 16'hFFFC);
    e_flag = 1; res_n = 0; cyc(3); res_n = 1; cyc(L + 6);
    chk("R11 reset vector emulation", last_vec, 16'hFFFC);

    // R10 wait released by masked irq
    e_flag = 0; i_flag = 1; c0 = seq_count;
    @(negedge clk); wai = 1; @(negedge clk); wai = 0; cyc(2);
    chk("R10 wait drops ready", ready, 0);
    irq_n = 0; cyc(5);
    chk("R10 masked irq raises ready", ready, 1);
    chk("R10 resume pulse", resume_count, 1);
    chk("R10 no vector", seq_count - c0, 0);
    irq_n = 1; cyc(3);

    // R10 wait released by nmi with a vector
    @(negedge clk); wai = 1; @(negedge clk); wai = 0; cyc(2);
    nmi_n = 0; cyc(1); nmi_n = 1; cyc(L + 5);
    chk("R10 nmi ends wait", ready, 1);
    chk("R10 nmi vector taken", last_vec, 16'hFFEA);
    i_flag = 0;

    // randomized mix against the model
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      boundary = ($urandom_range(0, 3) == 0);
      wai      = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 60) == 0) i_flag = ~i_flag;
      if ($urandom_range(0, 80) == 0) e_flag = ~e_flag;
      if ($urandom_range(0, 25) == 0) irq_n = ~irq_n;
      if ($urandom_range(0, 20) == 0) nmi_n = ~nmi_n;
      abt_n = ($urandom_range(0, 70) != 0);
      res_n = ($urandom_range(0, 400) != 0);
    end
    boundary = 0; wai = 0; res_n = 1; abt_n = 1; cyc(20);

    done = 1;
    summary();
    $finish;
  end
endmodule